// File: doc/BRIEF.md
# Capture-to-Trigger Mid-Point Compare Generator

This block serves resonant PWM control loops. In these loops a later event has to fire at the middle of the high time. The PWM time base is captured on a trigger event and presented to the block together with a capture strobe. The block subtracts the high-side dead time from the captured count and halves the difference. It then writes the result into one of four trigger compare registers, chosen by a 2-bit destination select that is sampled with the strobe.

Stores can be thinned in two ways. A one-time skip ignores a programmed number of eligible events after the function is enabled. After that, a postscaler lets only every (k+1)th remaining event through. The block keeps the last captured time-base value readable. A status flag reports that a fresh compare value has landed. The flag is cleared by a read of the capture register or by a write of the destination select.

Top module: `ctt_capture_trigger`

## Requirements
- R1: After a synchronous reset, all four compare registers, the capture register, every write strobe and the status flag are 0.
- R2: While `enable` is 0, no compare register changes, no write strobe is raised and the status flag is never set.
- R3: The stored value is (capture − dead_time) >> 1, treating both as 16-bit unsigned numbers. When dead_time is greater than or equal to the capture, the stored value is 0.
- R4: `dest_sel` is sampled in the cycle of the capture strobe. Its encoding is 0 = register C (trig_flat[15:0]), 1 = D ([31:16]), 2 = E ([47:32]) and 3 = F ([63:48]).
- R5: `trig_wr[i]` is high in the cycle after an accepted capture strobe, and only for the selected register. The register shows the new value from the following clock onward.
- R6: With postscale k, only every (k+1)th event that survives the skip is stored. A postscale of 0 stores every event.
- R7: With offset n, the first n capture strobes after enabling are dropped, once only. Later events are not skipped again.
- R8: Each 0-to-1 transition of `enable` reloads the skip count from `offset` and restarts the postscale count.
- R9: `status` goes to 1 on the clock after a write strobe. It goes to 0 after a cycle with `cap_rd` or `sel_wr` high. When a write strobe and a clear request fall in the same cycle, the set wins.
- R10: `cap_reg` takes `cap_value` on every capture strobe, whether `enable` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Function enable |
| cap_stb | input | 1 | Time-base capture strobe |
| cap_value | input | 16 | Captured time-base count |
| dead_time | input | 16 | High-side dead time |
| dest_sel | input | 2 | Destination compare register select |
| offset | input | 5 | One-time event skip count |
| postscale | input | 5 | Postscale setting (store every k+1 events) |
| cap_rd | input | 1 | Capture register read (clears status) |
| sel_wr | input | 1 | Destination select written (clears status) |
| cap_reg | output | 16 | Last captured time-base value |
| trig_flat | output | 64 | Four 16-bit compare registers, C in the low slice |
| trig_wr | output | 4 | Per-register write strobes |
| status | output | 1 | New compare value stored |

## Verification
The arithmetic is tried with a plain difference, an odd difference that shows truncation, dead time equal to and above the capture to show saturation, and a full-scale capture to show unsigned handling. Runs of strobes with distinct capture values under postscale and offset settings show exactly which events got through. A re-enable shows that the skip is armed again. Clears that coincide with a write show the priority, and a random phase with mixed enables, clears and select changes is compared against a behavioural model on every cycle.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
    localparam int DATA_W   = 16;
    localparam int CNT_W    = 5;
    localparam int NUM_DEST = 4;
    localparam int SEL_W    = $clog2(NUM_DEST);
    localparam int FLAT_W   = NUM_DEST * DATA_W;

    typedef logic [DATA_W-1:0] tb_word_t;
    typedef logic [SEL_W-1:0]  dest_t;

    typedef struct packed {
        logic     valid;
        dest_t    dest;
        tb_word_t value;
    } store_req_t;

    // Saturating subtract followed by a logical halving
    function automatic tb_word_t mid_point(input tb_word_t cap, input tb_word_t dt);
        tb_word_t diff;
        diff = (cap > dt) ? (cap - dt) : '0;
        return diff >> 1;
    endfunction
endpackage

// File: rtl/ctt_event_gate.sv
module ctt_event_gate #(
    parameter int CNT_W = ctt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             cap_stb,
    input  logic [CNT_W-1:0] offset,
    input  logic [CNT_W-1:0] postscale,
    output logic             fire
);
    logic [CNT_W-1:0] skip_q;
    logic [CNT_W-1:0] ps_q;
    logic             skipping;
    logic             ps_hit;

    assign skipping = (skip_q != '0);
    assign ps_hit   = (ps_q >= postscale);
    assign fire     = enable & cap_stb & ~skipping & ps_hit;

    // Counters are held at their reload values while disabled, so every
    // rising edge of enable starts from a fresh skip and postscale count.
    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            skip_q <= offset;
            ps_q   <= '0;
        end else if (cap_stb) begin
            if (skipping)
                skip_q <= skip_q - 1'b1;
            else if (ps_hit)
                ps_q <= '0;
            else
                ps_q <= ps_q + 1'b1;
        end
    end

    // R7: a skipped event consumes exactly one count
    a_r7_skip_counts_down: assert property (@(posedge clk) disable iff (rst)
        (enable && cap_stb && skip_q != '0) |=> (!enable || skip_q == $past(skip_q) - 1'b1));

    // R6: a store restarts the postscale count
    a_r6_restart_after_fire: assert property (@(posedge clk) disable iff (rst)
        fire |=> (ps_q == '0));

    // R8: a disabled cycle reloads the skip count
    a_r8_reload_on_idle: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (skip_q == $past(offset)));
endmodule

// File: rtl/ctt_compute.sv
module ctt_compute
    import ctt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic       cap_stb,
    input  tb_word_t   cap_value,
    input  tb_word_t   dead_time,
    input  dest_t      dest_sel,
    output store_req_t req,
    output tb_word_t   cap_reg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req     <= '0;
            cap_reg <= '0;
        end else begin
            req.valid <= fire;
            req.dest  <= dest_sel;
            req.value <= mid_point(cap_value, dead_time);
            if (cap_stb)
                cap_reg <= cap_value;
        end
    end

    // R10: the capture register follows every strobe
    a_r10_capture_kept: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> (cap_reg == $past(cap_value)));

    // R3: halving leaves the top bit clear
    a_r3_half_range: assert property (@(posedge clk) disable iff (rst)
        req.valid |-> !req.value[DATA_W-1]);

    // R3: dead time at or above the capture saturates to zero
    a_r3_saturate: assert property (@(posedge clk) disable iff (rst)
        (fire && dead_time >= cap_value) |=> (req.value == '0));
endmodule

// File: rtl/ctt_dest_bank.sv
module ctt_dest_bank
    import ctt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  store_req_t          req,
    output logic [FLAT_W-1:0]   trig_flat,
    output logic [NUM_DEST-1:0] trig_wr
);
    for (genvar i = 0; i < NUM_DEST; i++) begin : g_reg
        tb_word_t reg_q;

        assign trig_wr[i] = req.valid & enable & (req.dest == dest_t'(i));

        always_ff @(posedge clk) begin
            if (rst)
                reg_q <= '0;
            else if (trig_wr[i])
                reg_q <= req.value;
        end

        assign trig_flat[i*DATA_W +: DATA_W] = reg_q;

        // R4: a strobed register holds the pending value afterwards
        a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
            trig_wr[i] |=> (reg_q == $past(req.value)));
    end
endmodule

// File: rtl/ctt_capture_trigger.sv
module ctt_capture_trigger
    import ctt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                cap_stb,
    input  logic [DATA_W-1:0]   cap_value,
    input  logic [DATA_W-1:0]   dead_time,
    input  logic [SEL_W-1:0]    dest_sel,
    input  logic [CNT_W-1:0]    offset,
    input  logic [CNT_W-1:0]    postscale,
    input  logic                cap_rd,
    input  logic                sel_wr,
    output logic [DATA_W-1:0]   cap_reg,
    output logic [FLAT_W-1:0]   trig_flat,
    output logic [NUM_DEST-1:0] trig_wr,
    output logic                status
);
    logic       fire;
    store_req_t req;

    ctt_event_gate #(.CNT_W(CNT_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .cap_stb   (cap_stb),
        .offset    (offset),
        .postscale (postscale),
        .fire      (fire)
    );

    ctt_compute u_compute (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .cap_stb   (cap_stb),
        .cap_value (cap_value),
        .dead_time (dead_time),
        .dest_sel  (dest_sel),
        .req       (req),
        .cap_reg   (cap_reg)
    );

    ctt_dest_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .req       (req),
        .trig_flat (trig_flat),
        .trig_wr   (trig_wr)
    );

    // Set has priority over either clear source
    always_ff @(posedge clk) begin
        if (rst)
            status <= 1'b0;
        else if (|trig_wr)
            status <= 1'b1;
        else if (cap_rd || sel_wr)
            status <= 1'b0;
    end

    // R5: at most one destination written per cycle
    a_r5_onehot_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0(trig_wr));

    // R2: disabled cycles leave the compare registers untouched
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(trig_flat));

    // R2: disabled cycles never raise the status flag
    a_r2_no_status: assert property (@(posedge clk) disable iff (rst)
        (!enable && !status) |=> !status);

    // R9: a store sets the flag
    a_r9_status_set: assert property (@(posedge clk) disable iff (rst)
        (|trig_wr) |=> status);

    // R9: a clear without a store drops the flag
    a_r9_status_clear: assert property (@(posedge clk) disable iff (rst)
        ((cap_rd || sel_wr) && !(|trig_wr)) |=> !status);
endmodule

// File: tb/ctt_capture_trigger_tb.sv
module ctt_capture_trigger_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        enable = 0;
    logic        cap_stb = 0;
    logic [15:0] cap_value = 0;
    logic [15:0] dead_time = 0;
    logic [1:0]  dest_sel = 0;
    logic [4:0]  offset = 0;
    logic [4:0]  postscale = 0;
    logic        cap_rd = 0;
    logic        sel_wr = 0;
    logic [15:0] cap_reg;
    logic [63:0] trig_flat;
    logic [3:0]  trig_wr;
    logic        status;

    int errors = 0;
    int checks = 0;

    ctt_capture_trigger u_dut (
        .clk(clk), .rst(rst), .enable(enable), .cap_stb(cap_stb),
        .cap_value(cap_value), .dead_time(dead_time), .dest_sel(dest_sel),
        .offset(offset), .postscale(postscale), .cap_rd(cap_rd), .sel_wr(sel_wr),
        .cap_reg(cap_reg), .trig_flat(trig_flat), .trig_wr(trig_wr), .status(status)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Behavioural reference model
    int m_trig [4];
    int m_cap, m_skip, m_ps, m_pend_val, m_pend_dest;
    bit m_pend_v, m_status;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_trig[i]) m_trig[i] = 0;
            m_cap = 0; m_skip = offset; m_ps = 0;
            m_pend_v = 0; m_pend_dest = 0; m_pend_val = 0; m_status = 0;
        end else begin
            bit wr_now, take;
            wr_now = m_pend_v && enable;
            if (wr_now) m_trig[m_pend_dest] = m_pend_val;
            if (wr_now) m_status = 1;
            else if (cap_rd || sel_wr) m_status = 0;
            take = 0;
            if (!enable) begin
                m_skip = offset; m_ps = 0;
            end else if (cap_stb) begin
                if (m_skip > 0) m_skip--;
                else if (m_ps >= postscale) begin take = 1; m_ps = 0; end
                else m_ps++;
            end
            m_pend_v    = take;
            m_pend_dest = dest_sel;
            m_pend_val  = (cap_value > dead_time) ? (cap_value - dead_time) / 2 : 0;
            if (cap_stb) m_cap = cap_value;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            int exp_wr;
            for (int i = 0; i < 4; i++)
                chk(trig_flat[i*16 +: 16] == m_trig[i], "R3 compare value",
                    int'(trig_flat[i*16 +: 16]), m_trig[i]);
            exp_wr = (m_pend_v && enable) ? (1 << m_pend_dest) : 0;
            chk(trig_wr == exp_wr, "R5 write strobe", int'(trig_wr), exp_wr);
            chk(status == m_status, "R9 status", int'(status), int'(m_status));
            chk(cap_reg == m_cap, "R10 capture reg", int'(cap_reg), m_cap);
        end
    end

    function automatic int slot(input int i);
        return int'(trig_flat[i*16 +: 16]);
    endfunction

    task automatic strobe(input int cap, input int dt, input int sel);
        @(negedge clk); #1;
        cap_stb = 1; cap_value = cap[15:0]; dead_time = dt[15:0]; dest_sel = sel[1:0];
        @(negedge clk); #1;
        cap_stb = 0;
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic cycle_enable(input int off, input int ps);
        @(negedge clk); #1;
        enable = 0; offset = off[4:0]; postscale = ps[4:0];
        @(negedge clk); #1;
        enable = 1;
    endtask

    task automatic pulse_clear(input bit rd);
        @(negedge clk); #1;
        if (rd) cap_rd = 1; else sel_wr = 1;
        @(negedge clk); #1;
        cap_rd = 0; sel_wr = 0;
        @(negedge clk); #1;
    endtask

    initial begin
        #(4 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        @(negedge clk); #1;
        // R1 reset state
        chk(trig_flat == 0, "R1 compare regs", int'(trig_flat[31:0]), 0);
        chk(status == 0 && trig_wr == 0 && cap_reg == 0, "R1 flags", int'(status), 0);

        // R2 disabled: nothing written, capture still kept (R10)
        strobe(1000, 10, 0);
        strobe(2000, 10, 1);
        chk(trig_flat == 0, "R2 disabled no write", int'(trig_flat[31:0]), 0);
        chk(status == 0, "R2 disabled no status", int'(status), 0);
        chk(cap_reg == 2000, "R10 capture while disabled", int'(cap_reg), 2000);

        // R3 / R4 arithmetic and steering
        cycle_enable(0, 0);
        strobe(1000, 100, 0); chk(slot(0) == 450, "R3 plain diff", slot(0), 450);
        strobe(301, 0, 3);    chk(slot(3) == 150, "R3 truncation", slot(3), 150);
        strobe(50, 80, 1);    chk(slot(1) == 0, "R3 saturate", slot(1), 0);
        strobe(65535, 0, 2);  chk(slot(2) == 32767, "R3 full scale", slot(2), 32767);
        strobe(200, 200, 0);  chk(slot(0) == 0, "R3 equal saturates", slot(0), 0);
        chk(slot(3) == 150, "R4 other slots kept", slot(3), 150);
        chk(status == 1, "R9 set after store", int'(status), 1);

        // R6 postscale 2: stores on 3rd and 6th
        cycle_enable(0, 2);
        for (int i = 1; i <= 7; i++) begin
            strobe(10 * i + 100, 0, 1);
            if (i == 2) chk(slot(1) == 0, "R6 no store before 3rd", slot(1), 0);
            if (i == 3) chk(slot(1) == 65, "R6 3rd stored", slot(1), 65);
            if (i == 5) chk(slot(1) == 65, "R6 4th/5th dropped", slot(1), 65);
            if (i == 7) chk(slot(1) == 80, "R6 6th stored, 7th dropped", slot(1), 80);
        end

        // R7 offset 3: first three dropped, then every event
        cycle_enable(3, 0);
        for (int i = 1; i <= 5; i++) begin
            strobe(100 * i, 0, 2);
            if (i == 3) chk(slot(2) == 32767, "R7 skipped three", slot(2), 32767);
            if (i == 4) chk(slot(2) == 200, "R7 4th stored", slot(2), 200);
            if (i == 5) chk(slot(2) == 250, "R7 no re-skip", slot(2), 250);
        end

        // R8 re-enable re-arms the skip
        cycle_enable(3, 0);
        strobe(600, 0, 2);
        strobe(700, 0, 2);
        chk(slot(2) == 250, "R8 skip re-armed", slot(2), 250);

        // R9 clears and priority
        cycle_enable(0, 0);
        pulse_clear(1);
        chk(status == 0, "R9 cap read clears", int'(status), 0);
        strobe(40, 0, 0);
        pulse_clear(0);
        chk(status == 0, "R9 select write clears", int'(status), 0);
        @(negedge clk); #1;
        cap_stb = 1; cap_value = 16'd90; dead_time = 0; dest_sel = 0;
        @(negedge clk); #1;
        cap_stb = 0; cap_rd = 1;       // clear in the write cycle
        @(negedge clk); #1;
        cap_rd = 0;
        chk(status == 1, "R9 set wins over clear", int'(status), 1);
        chk(slot(0) == 45, "R5 value after strobe", slot(0), 45);

        // Random phase, compared against the model each cycle
        for (int n = 0; n < 600; n++) begin
            @(negedge clk); #1;
            enable    = ($urandom % 10) != 0;
            cap_stb   = ($urandom % 3) == 0;
            cap_value = 16'($urandom);
            dead_time = ($urandom % 2) ? 16'($urandom % 512) : 16'($urandom);
            dest_sel  = 2'($urandom);
            offset    = 5'($urandom % 4);
            postscale = 5'($urandom % 4);
            cap_rd    = ($urandom % 8) == 0;
            sel_wr    = ($urandom % 8) == 0;
        end
        @(negedge clk); #1;
        cap_stb = 0; cap_rd = 0; sel_wr = 0;
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule